// File: doc/BRIEF.md
# Dual-Bit Serial Command Transmitter

This block is a byte-oriented serial master for a bus shared by several devices. The host offers one byte at a time. With it come a mode flag, a two-bit device code and an end-of-command flag. The block clocks the byte out on a data-out line while it shifts in a reply from a data-in line. When the byte is finished it returns the received byte with a one-cycle done pulse.

There are two transfer modes:

- **Standard mode** sends one bit per serial clock, eight clocks per byte, most significant bit first.
- **Dual mode** sends two bits per serial clock, four clocks per byte. The upper bit of each pair goes out on data-out. The lower bit goes out on the third select line, which serves as a second data wire.

Device selection uses two active-low select lines:

- Device code 2 drives the second line low and leaves the first high.
- Every other code drives the first line low and leaves the second high.

A byte flagged as the end of a command releases both select lines once it completes.

Top module: `dual_bit_serial_tx`

## Requirements
- R1: After reset, busy, done and sclk are 0, and sel_a, sel_b and sel_c are all 1.
- R2: With req_dual=0, a byte is sent in 8 serial clock slots. Bit 7 goes first and bit 0 last, all on mosi. sel_c stays 1 for the whole byte.
- R3: With req_dual=1, a byte is sent in 4 slots carrying bit pairs (7,6), (5,4), (3,2), (1,0) in that order. In each pair the higher-numbered bit is on mosi and the lower-numbered bit is on sel_c.
- R4: Each slot holds sclk low for PHASE_CYC clock cycles and then high for PHASE_CYC cycles. mosi and sel_c do not change while sclk rises or stays high.
- R5: From the cycle after acceptance, device code 2 gives sel_a=1 and sel_b=0. Codes 0, 1 and 3 give sel_a=0 and sel_b=1. sel_a and sel_b are never low together.
- R6: If req_last was 1 with the byte, sel_a and sel_b are both 1 from the done cycle onward. If req_last was 0, the select pattern is held after done.
- R7: A request is accepted when req_valid=1 and busy=0. busy is then 1 for exactly slots*2*PHASE_CYC cycles starting the next cycle. done is 1 for the single cycle in which busy returns to 0.
- R8: miso is sampled at each clock edge where sclk rises and shifted in MSB first. In standard mode rx_byte holds the 8 samples on done. In dual mode rx_byte holds the 4 samples in bits 3..0, with the first sample in bit 3, and zeros in bits 7..4.
- R9: A request made while busy=1 is ignored: the byte in flight is sent unchanged and only one done pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request to send req_byte |
| req_byte | input | 8 | Byte to transmit |
| req_dual | input | 1 | 1 selects two bits per serial clock |
| req_dev | input | 2 | Target device code |
| req_last | input | 1 | Release selects after this byte |
| busy | output | 1 | Byte in flight |
| done | output | 1 | One-cycle pulse at end of byte |
| rx_byte | output | 8 | Byte received during the last transfer |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out (upper bit of a pair in dual mode) |
| sel_a | output | 1 | First select line, active low |
| sel_b | output | 1 | Second select line, active low |
| sel_c | output | 1 | Third select line; lower data bit in dual mode, else 1 |
| miso | input | 1 | Serial data in |

## Verification
On every cycle the checker holds the following invariants:

- sclk stays low when the block is idle.
- Data lines stay stable across the rising and high phase of each slot.
- sel_c stays high in standard mode.
- The two device selects never drop together.
- done is a single-cycle pulse that coincides with busy falling.

The directed scenarios cover what a property cannot see:

- the bit order and pairing of the transmitted byte in each mode;
- the exact phase lengths and byte duration;
- the received byte assembled from a modelled slave;
- the select pattern per device code and its release on an end-of-command byte;
- the dropping of a request that arrives mid-byte.

// File: rtl/dbst_pkg.sv
package dbst_pkg;
   localparam int BYTE_W   = 8;
   localparam int DEV_W    = 2;
   localparam int SHARED_DEV = 2;

   typedef struct packed {
      logic sel_a;
      logic sel_b;
   } sel_pair_t;

   localparam sel_pair_t SEL_IDLE = '{sel_a: 1'b1, sel_b: 1'b1};

   function automatic sel_pair_t dev_to_sel(input logic [DEV_W-1:0] dev);
      sel_pair_t s;
      if (dev == DEV_W'(SHARED_DEV)) begin
         s.sel_a = 1'b1;
         s.sel_b = 1'b0;
      end else begin
         s.sel_a = 1'b0;
         s.sel_b = 1'b1;
      end
      return s;
   endfunction
endpackage

// File: rtl/dbst_phase_timer.sv
module dbst_phase_timer #(
   parameter int PHASE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic tick
);
   generate
      if (PHASE_CYC < 1) begin : g_bad_phase
         $error("PHASE_CYC must be at least 1");
      end
      if (PHASE_CYC == 1) begin : g_single
         assign tick = run;
      end else begin : g_count
         localparam int CNT_W = $clog2(PHASE_CYC);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYC - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (restart) begin
               cnt_q <= '0;
            end else if (run) begin
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
         end
         assign tick = run && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/dbst_shifter.sv
module dbst_shifter #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_data,
   input  logic             dual,
   input  logic             advance,
   input  logic             sample,
   input  logic             sdi,
   output logic             hi_bit,
   output logic             lo_bit,
   output logic [WIDTH-1:0] rx_data
);
   generate
      if (WIDTH < 2 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("WIDTH must be even and at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] tx_q;
   logic [WIDTH-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         rx_q <= '0;
      end else if (load) begin
         tx_q <= load_data;
         rx_q <= '0;
      end else begin
         if (advance) tx_q <= dual ? (tx_q << 2) : (tx_q << 1);
         if (sample)  rx_q <= {rx_q[WIDTH-2:0], sdi};
      end
   end

   assign hi_bit  = tx_q[WIDTH-1];
   assign lo_bit  = tx_q[WIDTH-2];
   assign rx_data = rx_q;
endmodule

// File: rtl/dual_bit_serial_tx.sv
module dual_bit_serial_tx
   import dbst_pkg::*;
#(
   parameter int PHASE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [BYTE_W-1:0] req_byte,
   input  logic              req_dual,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic              req_last,
   output logic              busy,
   output logic              done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              sclk,
   output logic              mosi,
   output logic              sel_a,
   output logic              sel_b,
   output logic              sel_c,
   input  logic              miso
);
   localparam int SLOTS_STD  = BYTE_W;
   localparam int SLOTS_DUAL = BYTE_W / 2;
   localparam int SLOT_W     = $clog2(SLOTS_STD);

   logic              busy_q, done_q, sclk_q, dual_q, last_q;
   logic [SLOT_W-1:0] slots_left_q;
   sel_pair_t         sel_q;
   logic [BYTE_W-1:0] rx_q;
   logic              accept, tick, rise, finish, advance;
   logic              hi_bit, lo_bit;
   logic [BYTE_W-1:0] rx_shift;

   assign accept  = req_valid && !busy_q;
   assign rise    = tick && !sclk_q;
   assign finish  = tick && sclk_q && (slots_left_q == '0);
   assign advance = tick && sclk_q && (slots_left_q != '0);

   dbst_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .run     (busy_q),
      .tick    (tick)
   );

   dbst_shifter #(.WIDTH(BYTE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_data (req_byte),
      .dual      (dual_q),
      .advance   (advance),
      .sample    (rise),
      .sdi       (miso),
      .hi_bit    (hi_bit),
      .lo_bit    (lo_bit),
      .rx_data   (rx_shift)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q       <= 1'b0;
         done_q       <= 1'b0;
         sclk_q       <= 1'b0;
         dual_q       <= 1'b0;
         last_q       <= 1'b0;
         slots_left_q <= '0;
         sel_q        <= SEL_IDLE;
         rx_q         <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q       <= 1'b1;
            sclk_q       <= 1'b0;
            dual_q       <= req_dual;
            last_q       <= req_last;
            slots_left_q <= req_dual ? SLOT_W'(SLOTS_DUAL - 1) : SLOT_W'(SLOTS_STD - 1);
            sel_q        <= dev_to_sel(req_dev);
         end else if (rise) begin
            sclk_q <= 1'b1;
         end else if (advance) begin
            sclk_q       <= 1'b0;
            slots_left_q <= slots_left_q - 1'b1;
         end else if (finish) begin
            sclk_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            rx_q   <= rx_shift;
            if (last_q) sel_q <= SEL_IDLE;
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign rx_byte = rx_q;
   assign sclk    = sclk_q;
   assign mosi    = busy_q ? hi_bit : 1'b0;
   assign sel_c   = (busy_q && dual_q) ? lo_bit : 1'b1;
   assign sel_a   = sel_q.sel_a;
   assign sel_b   = sel_q.sel_b;
endmodule

// File: rtl/dbst_checker.sv
module dbst_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic sclk,
   input logic mosi,
   input logic sel_a,
   input logic sel_b,
   input logic sel_c,
   input logic dual_q
);
   // R4
   idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

   // R4
   data_held_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(busy)) |-> ($stable(mosi) && $stable(sel_c)));

   // R2
   std_sel_c_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !dual_q) |-> sel_c);

   // R5
   sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a || sel_b));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind dual_bit_serial_tx dbst_checker u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy   (busy),
   .done   (done),
   .sclk   (sclk),
   .mosi   (mosi),
   .sel_a  (sel_a),
   .sel_b  (sel_b),
   .sel_c  (sel_c),
   .dual_q (dual_q)
);

// File: tb/dual_bit_serial_tx_bench.sv
module dual_bit_serial_tx_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PHASE      = 2;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [7:0] req_byte = '0;
   logic       req_dual = 1'b0;
   logic [1:0] req_dev = '0;
   logic       req_last = 1'b0;
   logic       miso = 1'b0;
   logic       busy, done, sclk, mosi, sel_a, sel_b, sel_c;
   logic [7:0] rx_byte;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_bit_serial_tx #(.PHASE_CYC(PHASE)) u_dual_bit_serial_tx (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_byte(req_byte),
      .req_dual(req_dual), .req_dev(req_dev), .req_last(req_last),
      .busy(busy), .done(done), .rx_byte(rx_byte), .sclk(sclk),
      .mosi(mosi), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .miso(miso)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b, input bit dual, input logic [1:0] dev,
                       input bit last, input logic [7:0] slave, input bit inject);
      logic [7:0] got = '0;
      logic [7:0] exp_rx;
      int  slots = 0, busy_cyc = 0, run = 0, low_len = -1, high_len = -1;
      int  dones = 0, idx = 0, guard = 0;
      bit  prev = 0, selc_ok = 1, sel_ok = 1, phase_ok = 1;
      int  n_slots = dual ? 4 : 8;
      @(negedge clk);
      req_valid = 1; req_byte = b; req_dual = dual; req_dev = dev; req_last = last;
      miso = slave[7];
      @(negedge clk);
      req_valid = 0;
      while (!done && guard < 1000) begin
         guard++;
         if (busy) busy_cyc++;
         if (inject && busy_cyc == 3) begin
            req_valid = 1; req_byte = ~b; req_dual = ~dual; req_dev = 2'd2;
         end else begin
            req_valid = 0;
         end
         if ((dev == 2'd2) ? (sel_a !== 1 || sel_b !== 0) : (sel_a !== 0 || sel_b !== 1))
            sel_ok = 0;
         if (!dual && sel_c !== 1) selc_ok = 0;
         if (sclk && !prev) begin
            slots++;
            got = dual ? {got[5:0], mosi, sel_c} : {got[6:0], mosi};
            if (run != PHASE) phase_ok = 0;
            if (low_len < 0) low_len = run;
            run = 1;
         end else if (!sclk && prev) begin
            if (run != PHASE) phase_ok = 0;
            if (high_len < 0) high_len = run;
            run = 1;
            idx++;
            if (idx < 8) miso = slave[7-idx];
         end else begin
            run++;
         end
         prev = sclk;
         @(negedge clk);
      end
      req_valid = 0;
      // done cycle: final high phase ended
      if (prev && run != PHASE) phase_ok = 0;
      dones = done ? 1 : 0;
      exp_rx = dual ? {4'b0, slave[7:4]} : slave;
      if (dual) begin
         check(got == b, "R3", got, b);
      end else begin
         check(got == b, "R2", got, b);
         check(selc_ok, "R2", selc_ok, 1);
      end
      check(slots == n_slots, dual ? "R3" : "R2", slots, n_slots);
      check(phase_ok && low_len == PHASE && high_len == PHASE, "R4", low_len, PHASE);
      check(busy_cyc == n_slots * 2 * PHASE, "R7", busy_cyc, n_slots * 2 * PHASE);
      check(dones == 1 && busy == 0, "R7", dones, 1);
      check(rx_byte == exp_rx, "R8", rx_byte, exp_rx);
      check(sel_ok, "R5", sel_ok, 1);
      if (last)
         check(sel_a === 1 && sel_b === 1, "R6", {sel_a, sel_b}, 3);
      else
         check((dev == 2'd2) ? (sel_a === 1 && sel_b === 0) : (sel_a === 0 && sel_b === 1),
               "R6", {sel_a, sel_b}, (dev == 2'd2) ? 2 : 1);
      @(negedge clk);
      check(done == 0 && busy == 0, "R9", {done, busy}, 0);
      if (last) check(sel_a === 1 && sel_b === 1, "R6", {sel_a, sel_b}, 3);
   endtask

   task automatic test_reset();
      check(busy == 0 && done == 0 && sclk == 0, "R1", {busy, done, sclk}, 0);
      check(sel_a == 1 && sel_b == 1 && sel_c == 1, "R1", {sel_a, sel_b, sel_c}, 7);
   endtask

   task automatic test_standard();
      send(8'hA5, 0, 2'd0, 0, 8'h3C, 0);
      send(8'h81, 0, 2'd1, 1, 8'hC3, 0);
   endtask

   task automatic test_dual();
      send(8'h1B, 1, 2'd2, 0, 8'h96, 0);
      send(8'hE4, 1, 2'd2, 1, 8'h5A, 0);
   endtask

   task automatic test_dev3_and_ignore();
      send(8'h6D, 0, 2'd3, 1, 8'hF0, 1);  // R9 request mid-byte dropped
   endtask

   initial begin
      @(negedge clk);
      test_reset();
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      test_reset();
      test_standard();
      test_dual();
      test_dev3_and_ignore();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule